// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two multi-byte words, P and Q, and reports two decoded results: P greater than Q and P less than Q. There is no equal output. Both results low means the words are equal, provided the cascade inputs are low. The word is split into byte-wide stages. Each stage compares its own byte of P and Q. Each stage takes the greater and less flags of the stage below it and uses them only when its own bytes are equal. Stages therefore chain with no extra gating between them. The chain's own cascade inputs let several chains be joined to compare wider words.

The P operand passes through a level-sensitive latch. The latch is transparent while the latch enable is high and holds its value while the enable is low. It clears to zero while reset is asserted. Q is used live. The comparison is purely combinational from the latched P and the live Q.

A mode input selects an unsigned comparison or a two's-complement comparison. Only the most significant stage treats its byte as signed. Lower stages always compare unsigned, so a full-width signed compare comes out correct.

Top module: `mag_cmp_chain`

## Requirements
- R1: While rst_ni is low the P latch holds zero, whatever p_i and ple_i do. With q_i = 0 and gt_i = lt_i = 0, both outputs are then low. With q_i = 1, lt_o is high.
- R2: While ple_i is high (and rst_ni high), the outputs follow the live p_i.
- R3: While ple_i is low, changes on p_i have no effect on the outputs. The comparison uses the last P value seen while ple_i was high.
- R4: With arith_i = 0 the words are compared as unsigned. For example, 16'h8000 is greater than 16'h7F00.
- R5: With arith_i = 1 the words are compared as two's complement. For example, 16'h8000 is less than 16'h7F00, and 16'hFFFF is less than 16'h0000.
- R6: When the latched P equals q_i, gt_o copies gt_i and lt_o copies lt_i. This includes the case where both cascade inputs are high.
- R7: When the latched P differs from q_i, exactly one of gt_o and lt_o is high, and the cascade inputs have no effect.
- R8: Only the top byte is signed in arithmetic mode. With equal top bytes, lower bytes compare unsigned, so 16'h0080 is greater than 16'h007F in both modes.
- R9: A difference in a more significant byte decides the result, whatever the lower bytes hold. For example, 16'h0100 is greater than 16'h00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous clear of the P latch |
| ple_i | input | 1 | P latch enable, transparent when high |
| arith_i | input | 1 | 1 = two's-complement compare, 0 = unsigned |
| p_i | input | STAGES*BYTE_W (16) | P operand, before the latch |
| q_i | input | STAGES*BYTE_W (16) | Q operand, live |
| gt_i | input | 1 | Greater flag from a less significant chain |
| lt_i | input | 1 | Less flag from a less significant chain |
| gt_o | output | 1 | Latched P greater than Q |
| lt_o | output | 1 | Latched P less than Q |

## Verification
Each stage carries assertions that are evaluated whenever its inputs change. They check that equal bytes pass the cascade flags through unchanged, and that differing bytes give exactly one flag. They also check the unsigned and signed ordering against independent comparison expressions. Latch behaviour cannot be seen inside one stage: clear under reset, transparency, and hold against changing p_i. Only the bench's directed sequences show these. Whole-word ordering across stages, including the mixed signed-top and unsigned-lower case, is checked by the bench's vector table and its random comparison against a reference model.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_flags_t;
endpackage

// File: rtl/mag_latch.sv
module mag_latch #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // R1 clear dominates, R2/R3 transparent when high, hold when low
  always_latch begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/mag_stage.sv
module mag_stage
  import cmp_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] q_i,
  input  logic         signed_i,
  input  cmp_flags_t   cas_i,
  output cmp_flags_t   res_o
);
  localparam logic [W-1:0] SIGN_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] key_p, key_q;
  logic         eq;
  cmp_flags_t   res;

  always_comb begin
    eq    = (p_i == q_i);
    // flipping the sign bit maps two's complement onto unsigned order
    key_p = signed_i ? (p_i ^ SIGN_MASK) : p_i;
    key_q = signed_i ? (q_i ^ SIGN_MASK) : q_i;
    if (eq) begin
      res = cas_i;
    end else begin
      res.gt = (key_p > key_q);
      res.lt = ~res.gt;
    end

    if (!$isunknown({p_i, q_i, signed_i, cas_i})) begin
      a_r6_equal_pass : assert (!eq || (res == cas_i))
        else $error("a_r6_equal_pass");
      a_r7_one_flag : assert (eq || (res.gt ^ res.lt))
        else $error("a_r7_one_flag");
      a_r4_unsigned_order : assert (signed_i || eq || (p_i[W-1] == q_i[W-1])
                                    || (res.gt == p_i[W-1]))
        else $error("a_r4_unsigned_order");
      a_r5_signed_order : assert (!signed_i || eq
                                  || (res.gt == ($signed(p_i) > $signed(q_i))))
        else $error("a_r5_signed_order");
    end
  end

  assign res_o = res;
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import cmp_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = BYTE_W
) (
  input  logic                  rst_ni,
  input  logic                  ple_i,
  input  logic                  arith_i,
  input  logic [STAGES*W-1:0]   p_i,
  input  logic [STAGES*W-1:0]   q_i,
  input  logic                  gt_i,
  input  logic                  lt_i,
  output logic                  gt_o,
  output logic                  lt_o
);
  localparam int unsigned TOP = STAGES - 1;

  cmp_flags_t chain [STAGES+1];

  assign chain[0].gt = gt_i;
  assign chain[0].lt = lt_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] p_lat;
    // R8: only the most significant stage interprets its byte as signed
    localparam bit IS_TOP = (s == TOP);

    mag_latch #(.W(W)) u_latch (
      .rst_ni (rst_ni),
      .en_i   (ple_i),
      .d_i    (p_i[s*W +: W]),
      .q_o    (p_lat)
    );

    mag_stage #(.W(W)) u_stage (
      .p_i      (p_lat),
      .q_i      (q_i[s*W +: W]),
      .signed_i (IS_TOP ? arith_i : 1'b0),
      .cas_i    (chain[s]),
      .res_o    (chain[s+1])
    );
  end

  // R9: the top stage result is final; lower ones only reach it through ties
  assign gt_o = chain[STAGES].gt;
  assign lt_o = chain[STAGES].lt;
endmodule

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;
  logic        clk = 1'b0;
  logic        rst_ni, ple_i, arith_i, gt_i, lt_i;
  logic [15:0] p_i, q_i;
  logic        gt_o, lt_o;
  int          total = 0;
  int          bad   = 0;

  always #5 clk = ~clk;

  mag_cmp_chain u_mag_cmp_chain (
    .rst_ni (rst_ni), .ple_i (ple_i), .arith_i (arith_i),
    .p_i (p_i), .q_i (q_i), .gt_i (gt_i), .lt_i (lt_i),
    .gt_o (gt_o), .lt_o (lt_o)
  );

  // {arith, p, q, gt_in, lt_in, exp_gt, exp_lt}
  localparam int NV = 11;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 16'h0080, 16'h007F, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 unsigned
    {1'b1, 16'h0080, 16'h007F, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 arith
    {1'b0, 16'h8000, 16'h7F00, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
    {1'b1, 16'h8000, 16'h7F00, 1'b0, 1'b0, 1'b0, 1'b1}, // R5
    {1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1}, // R5
    {1'b1, 16'h1234, 16'h1234, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 both high
    {1'b0, 16'h1234, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b1}, // R6
    {1'b0, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 equal
    {1'b0, 16'h1235, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 cascade ignored
    {1'b0, 16'h0100, 16'h00FF, 1'b0, 1'b0, 1'b1, 1'b0}, // R9
    {1'b1, 16'hFF00, 16'h00FF, 1'b1, 1'b1, 1'b0, 1'b1}  // R9 signed top
  };

  function automatic logic [1:0] ref_cmp(input logic a, input logic [15:0] p,
                                         input logic [15:0] q, input logic gi,
                                         input logic li);
    logic g;
    if (p == q) return {gi, li};
    g = a ? ($signed(p) > $signed(q)) : (p > q);
    return {g, ~g};
  endfunction

  task automatic check(input string req, input logic eg, input logic el);
    total++;
    if (gt_o !== eg || lt_o !== el) begin
      bad++;
      $display("FAIL %s: got gt=%b lt=%b expected gt=%b lt=%b (p=%h q=%h)",
               req, gt_o, lt_o, eg, el, p_i, q_i);
    end
  endtask

  task automatic drive(input logic a, input logic [15:0] p, input logic [15:0] q,
                       input logic gi, input logic li);
    @(negedge clk);
    arith_i = a; p_i = p; q_i = q; gt_i = gi; lt_i = li;
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; ple_i = 1'b1; arith_i = 1'b0;
    p_i = 16'h5555; q_i = 16'h0000; gt_i = 1'b0; lt_i = 1'b0;

    // R1: reset dominates an open latch
    drive(1'b0, 16'h5555, 16'h0000, 1'b0, 1'b0);
    check("R1", 1'b0, 1'b0);
    drive(1'b0, 16'h5555, 16'h0001, 1'b0, 1'b0);
    check("R1", 1'b0, 1'b1);

    @(negedge clk); rst_ni = 1'b1;
    // R2: transparent
    drive(1'b0, 16'h5555, 16'h5555, 1'b0, 1'b0);
    check("R2", 1'b0, 1'b0);
    drive(1'b0, 16'h6000, 16'h5555, 1'b0, 1'b0);
    check("R2", 1'b1, 1'b0);

    // R3: hold
    @(negedge clk); ple_i = 1'b0;
    drive(1'b0, 16'h0000, 16'h5555, 1'b0, 1'b0);
    check("R3", 1'b1, 1'b0);
    drive(1'b0, 16'hFFFF, 16'h7000, 1'b0, 1'b0);
    check("R3", 1'b0, 1'b1);
    drive(1'b0, 16'h1111, 16'h6000, 1'b0, 1'b0);
    check("R3", 1'b0, 1'b0);
    @(negedge clk); ple_i = 1'b1;
    drive(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R2", 1'b0, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][36], VEC[i][35:20], VEC[i][19:4], VEC[i][3], VEC[i][2]);
      check("R4-table", VEC[i][1], VEC[i][0]);
    end

    // random against reference, R7 and R6
    for (int i = 0; i < 300; i++) begin
      logic [15:0] rp, rq;
      logic [1:0]  e;
      logic        ra, rg, rl;
      rp = 16'($urandom); rq = 16'($urandom);
      ra = 1'($urandom); rg = 1'($urandom); rl = 1'($urandom);
      if (i % 5 == 0) rq = rp;
      else if (i % 5 == 1) rq = {rp[15:8], rq[7:0]};
      e = ref_cmp(ra, rp, rq, rg, rl);
      drive(ra, rp, rq, rg, rl);
      check((rp == rq) ? "R6" : "R7", e[1], e[0]);
    end

    // R1: reset reasserted clears a held value
    @(negedge clk); ple_i = 1'b0; rst_ni = 1'b0;
    drive(1'b0, 16'hABCD, 16'h0000, 1'b0, 1'b0);
    check("R1", 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule